// File: doc/BRIEF.md
# AMI Line Monitor with Carrier-Loss Detection

This block sits at the receive end of an alternate-mark-inversion T1 line. It takes the two rail inputs (one pulses for positive marks, the other for negative marks) and produces a single NRZ serial stream. It marks every bipolar violation on the output bit that caused it. It also raises a carrier-loss flag when the line stays silent for too long.

The rails are captured on the falling edge of the receive clock. The NRZ bit, the violation flag and the carrier-loss flag all change together on the following rising edge, so the flags line up with the bit they describe. When both rails are tied together to carry plain NRZ data, the block recognises this from the data itself and stops reporting violations.

Carrier loss has hysteresis. It is declared on a fixed run of zeros. It is withdrawn only after the line has shown the minimum ones density over a window of the same length.

Top module: `ami_line_monitor`

## Requirements
- R1: Both rails are sampled on the falling clock edge. The NRZ output is the OR of the two sampled rails and appears on the next rising edge, so each bit takes one cycle.
- R2: A single-rail mark whose polarity equals that of the last remembered mark sets the violation output, in the same cycle that the mark is on the NRZ output. Marks that alternate never set it, and zeros between marks do not change the remembered polarity.
- R3: After reset no polarity is remembered, so the first single-rail mark is never flagged.
- R4: In bipolar mode, a mark with both rails high is flagged as a violation. It also clears the remembered polarity, so the next single-rail mark is not flagged.
- R5: Both-rail marks are counted, with zeros between them ignored. With NRZ_DETECT = 4, the first three consecutive both-rail marks are flagged, and the fourth and every later one is not (NRZ mode). Any single-rail mark resets the count and returns the block to bipolar mode.
- R6: The violation output is only ever high while the NRZ output is high.
- R7: The carrier-loss output rises in the same cycle as the 192nd consecutive zero on the NRZ output. After 191 zeros it is still low.
- R8: While carrier loss is set, bits are grouped into windows of 8, starting with the bit after the one that set it. A window holding at least one mark is good, and a window without a mark resets the good count to zero. The flag falls in the cycle of the last bit of the 24th consecutive good window.
- R9: While reset is held and right after it, the NRZ, violation and carrier-loss outputs are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive line clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_p_i | input | 1 | Positive-mark rail |
| rail_n_i | input | 1 | Negative-mark rail |
| nrz_o | output | 1 | Recovered NRZ data |
| viol_o | output | 1 | Bipolar violation on the current NRZ bit |
| carrier_lost_o | output | 1 | Carrier-loss flag |

## Verification
The hardest state to reach from the ports is the release of carrier loss. It needs 192 zeros first, then 24 window-aligned good windows in a row, and the release edge depends on where the window boundary falls.

The bench drives this directly. It builds the windows bit by bit, with the single mark at varying positions, including the last bit of a window. Partway through it inserts an empty window, so the count has to restart before the final release.

Mode switching is reached with a long stretch of identical rails, followed by a single-rail mark.

// File: rtl/ami_mon_pkg.sv
package ami_mon_pkg;
  typedef enum logic [1:0] {
    SYM_SPACE = 2'b00,
    SYM_NEG   = 2'b01,
    SYM_POS   = 2'b10,
    SYM_BOTH  = 2'b11
  } sym_e;

  function automatic sym_e f_classify(input logic p, input logic n);
    return sym_e'({p, n});
  endfunction

  function automatic logic f_is_mark(input sym_e s);
    return s != SYM_SPACE;
  endfunction

  function automatic logic f_is_single(input sym_e s);
    return (s == SYM_POS) || (s == SYM_NEG);
  endfunction

  // a single-rail mark repeating the last remembered polarity
  function automatic logic f_repeat_polarity(input logic have_last,
                                             input logic last_pos,
                                             input sym_e s);
    return have_last && f_is_single(s) && (last_pos == (s == SYM_POS));
  endfunction
endpackage

// File: rtl/ami_rail_sampler.sv
module ami_rail_sampler
  import ami_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rail_p_i,
  input  logic rail_n_i,
  output sym_e sym_o
);
  logic p_s, n_s;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_s <= 1'b0;
      n_s <= 1'b0;
    end else begin
      p_s <= rail_p_i;
      n_s <= rail_n_i;
    end
  end

  assign sym_o = f_classify(p_s, n_s);
endmodule

// File: rtl/ami_violation_check.sv
module ami_violation_check
  import ami_mon_pkg::*;
#(
  parameter int NRZ_DETECT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  sym_e sym_i,
  output logic viol_o,
  output logic nrz_mode_o
);
  localparam int BW = $clog2(NRZ_DETECT + 1);

  logic          have_q, have_d;
  logic          last_pos_q, last_pos_d;
  logic [BW-1:0] both_q, both_d;
  logic          viol_q, viol_d;
  logic          nrz_mode;

  assign nrz_mode = (both_q == BW'(NRZ_DETECT));

  always_comb begin
    have_d     = have_q;
    last_pos_d = last_pos_q;
    both_d     = both_q;
    viol_d     = 1'b0;
    unique case (sym_i)
      SYM_BOTH: begin
        viol_d = (both_q < BW'(NRZ_DETECT - 1));
        have_d = 1'b0;
        both_d = nrz_mode ? both_q : both_q + 1'b1;
      end
      SYM_POS, SYM_NEG: begin
        viol_d     = f_repeat_polarity(have_q, last_pos_q, sym_i);
        have_d     = 1'b1;
        last_pos_d = (sym_i == SYM_POS);
        both_d     = '0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q     <= 1'b0;
      last_pos_q <= 1'b0;
      both_q     <= '0;
      viol_q     <= 1'b0;
    end else begin
      have_q     <= have_d;
      last_pos_q <= last_pos_d;
      both_q     <= both_d;
      viol_q     <= viol_d;
    end
  end

  assign viol_o     = viol_q;
  assign nrz_mode_o = nrz_mode;

  // R5
  nrz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nrz_mode && sym_i == SYM_BOTH) |=> !viol_q);
  // R6
  space_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_i == SYM_SPACE) |=> !viol_q);
  // R3
  first_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!have_q && f_is_single(sym_i)) |=> !viol_q);
  // R2
  repeat_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have_q && sym_i == SYM_POS && last_pos_q) |=> viol_q);
endmodule

// File: rtl/ami_carrier_watch.sv
module ami_carrier_watch #(
  parameter int LOSS_ZEROS = 192,
  parameter int WIN_BITS   = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_i,
  output logic lost_o
);
  localparam int CLEAR_WINDOWS = LOSS_ZEROS / WIN_BITS;
  localparam int ZW = $clog2(LOSS_ZEROS + 1);
  localparam int IW = $clog2(WIN_BITS);
  localparam int GW = $clog2(CLEAR_WINDOWS + 1);

  logic [ZW-1:0] zero_run_q, zero_run_d;
  logic [IW-1:0] win_idx_q;
  logic [GW-1:0] good_q, good_d;
  logic          seen_q, lost_q;
  logic          loss_event, win_end, win_good, restore_event;

  always_comb begin
    if (mark_i)
      zero_run_d = '0;
    else if (zero_run_q == ZW'(LOSS_ZEROS))
      zero_run_d = zero_run_q;
    else
      zero_run_d = zero_run_q + 1'b1;
  end

  assign loss_event    = !lost_q && (zero_run_d == ZW'(LOSS_ZEROS));
  assign win_end       = lost_q && (win_idx_q == IW'(WIN_BITS - 1));
  assign win_good      = seen_q | mark_i;
  assign good_d        = win_good ? good_q + 1'b1 : '0;
  assign restore_event = win_end && win_good && (good_q == GW'(CLEAR_WINDOWS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zero_run_q <= '0;
      win_idx_q  <= '0;
      good_q     <= '0;
      seen_q     <= 1'b0;
      lost_q     <= 1'b0;
    end else begin
      zero_run_q <= zero_run_d;
      if (loss_event) begin
        lost_q    <= 1'b1;
        win_idx_q <= '0;
        seen_q    <= 1'b0;
        good_q    <= '0;
      end else if (lost_q) begin
        if (win_end) begin
          win_idx_q <= '0;
          seen_q    <= 1'b0;
          good_q    <= good_d;
          if (restore_event) lost_q <= 1'b0;
        end else begin
          win_idx_q <= win_idx_q + 1'b1;
          seen_q    <= seen_q | mark_i;
        end
      end
    end
  end

  assign lost_o = lost_q;

  // R7
  loss_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lost_q && !mark_i && zero_run_q == ZW'(LOSS_ZEROS - 1)) |=> lost_q);
  // R7
  no_early_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lost_q) |-> (zero_run_q == ZW'(LOSS_ZEROS)));
  // R8
  clear_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lost_q) |-> (win_idx_q == '0 && good_q == GW'(CLEAR_WINDOWS)));
  // R8
  empty_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_end && !win_good) |=> (lost_q && good_q == '0));
endmodule

// File: rtl/ami_line_monitor.sv
module ami_line_monitor
  import ami_mon_pkg::*;
#(
  parameter int LOSS_ZEROS = 192,
  parameter int WIN_BITS   = 8,
  parameter int NRZ_DETECT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rail_p_i,
  input  logic rail_n_i,
  output logic nrz_o,
  output logic viol_o,
  output logic carrier_lost_o
);
  sym_e sym;
  logic nrz_q;
  logic nrz_mode;

  ami_rail_sampler u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .rail_p_i (rail_p_i),
    .rail_n_i (rail_n_i),
    .sym_o    (sym)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nrz_q <= 1'b0;
    else        nrz_q <= f_is_mark(sym);
  end

  ami_violation_check #(.NRZ_DETECT(NRZ_DETECT)) u_viol (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_i      (sym),
    .viol_o     (viol_o),
    .nrz_mode_o (nrz_mode)
  );

  ami_carrier_watch #(.LOSS_ZEROS(LOSS_ZEROS), .WIN_BITS(WIN_BITS)) u_carrier (
    .clk    (clk),
    .rst_n  (rst_n),
    .mark_i (f_is_mark(sym)),
    .lost_o (carrier_lost_o)
  );

  assign nrz_o = nrz_q;

  // R6
  viol_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> nrz_o);
  // R5
  nrz_mode_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nrz_mode && $stable(nrz_mode) && !$isunknown(sym) && sym == SYM_BOTH) |=> !viol_o);
endmodule

// File: tb/ami_line_monitor_tb.sv
module ami_line_monitor_tb;
  localparam int LOSS = 192;
  localparam int WIN  = 8;
  localparam int DET  = 4;
  localparam int CLRW = LOSS / WIN;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rp = 1'b0, rn = 1'b0;
  logic nrz, viol, lost;

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  int m_have, m_last, m_both, m_zr, m_lost, m_widx, m_seen, m_good;
  bit e_nrz, e_viol;

  always #10 clk = ~clk;

  ami_line_monitor #(.LOSS_ZEROS(LOSS), .WIN_BITS(WIN), .NRZ_DETECT(DET)) u_dut (
    .clk(clk), .rst_n(rst_n), .rail_p_i(rp), .rail_n_i(rn),
    .nrz_o(nrz), .viol_o(viol), .carrier_lost_o(lost)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_have = 0; m_last = 0; m_both = 0; m_zr = 0;
    m_lost = 0; m_widx = 0; m_seen = 0; m_good = 0;
  endtask

  task automatic model_bit(input bit p, input bit n);
    e_nrz  = p | n;
    e_viol = 0;
    if (p && n) begin
      e_viol = (m_both + 1) < DET;
      if (m_both < DET) m_both++;
      m_have = 0;
    end else if (p != n) begin
      e_viol = m_have && (m_last == int'(p));
      m_have = 1; m_last = int'(p); m_both = 0;
    end
    m_zr = e_nrz ? 0 : ((m_zr < LOSS) ? m_zr + 1 : LOSS);
    if (!m_lost) begin
      if (m_zr == LOSS) begin
        m_lost = 1; m_widx = 0; m_seen = 0; m_good = 0;
      end
    end else begin
      m_seen = m_seen | int'(e_nrz);
      if (m_widx == WIN - 1) begin
        m_good = m_seen ? m_good + 1 : 0;
        m_seen = 0; m_widx = 0;
        if (m_good == CLRW) m_lost = 0;
      end else m_widx++;
    end
  endtask

  // one line bit per clock: drive, falling-edge capture, rising-edge update
  task automatic step(input bit p, input bit n);
    rp = p; rn = n;
    @(negedge clk);
    @(posedge clk);
    #3;
    model_bit(p, n);
    chk(nrz == e_nrz, "R1 nrz", nrz, e_nrz);
    chk(viol == e_viol, "R2 viol", viol, e_viol);
    chk(lost == m_lost[0], "R7 carrier", lost, m_lost);
    chk(!(viol && !nrz), "R6 viol without mark", viol, 0);
  endtask

  initial begin
    bit pol;
    logic [15:0] lf;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    // R9 during reset
    chk(nrz == 0 && viol == 0 && lost == 0, "R9 in reset", {nrz, viol, lost}, 0);
    @(posedge clk);
    #3 rst_n = 1'b1;
    chk(nrz == 0 && viol == 0 && lost == 0, "R9 after reset", {nrz, viol, lost}, 0);

    // R3 first mark not flagged
    step(0, 0);
    step(1, 0); chk(viol == 0, "R3 first mark", viol, 0);
    step(0, 0);
    step(1, 0); chk(viol == 1, "R2 repeated positive", viol, 1);
    step(0, 1); chk(viol == 0, "R2 alternation", viol, 0);
    step(0, 0); step(0, 0);
    step(0, 1); chk(viol == 1, "R2 repeated negative across zeros", viol, 1);
    // R4 both-rail mark in bipolar mode
    step(1, 1); chk(viol == 1, "R4 both rails flagged", viol, 1);
    step(0, 1); chk(viol == 0, "R4 memory cleared", viol, 0);
    step(1, 0);
    // R5 NRZ detection with zeros in between
    step(1, 1); chk(viol == 1, "R5 both #1", viol, 1);
    step(0, 0);
    step(1, 1); chk(viol == 1, "R5 both #2", viol, 1);
    step(1, 1); chk(viol == 1, "R5 both #3", viol, 1);
    step(0, 0);
    step(1, 1); chk(viol == 0, "R5 both #4 quiet", viol, 0);
    step(1, 1); chk(viol == 0, "R5 nrz mode quiet", viol, 0);
    step(0, 1); chk(viol == 0, "R5 exit mark", viol, 0);
    step(0, 1); chk(viol == 1, "R5 bipolar again", viol, 1);

    // R7 boundary 191 / 192
    step(1, 0);
    for (int i = 0; i < LOSS - 1; i++) step(0, 0);
    chk(lost == 0, "R7 after 191 zeros", lost, 0);
    step(0, 0);
    chk(lost == 1, "R7 after 192 zeros", lost, 1);

    // R8 density recovery with a reset of the good count
    pol = 0;
    for (int w = 0; w < CLRW - 1; w++)
      for (int b = 0; b < WIN; b++) begin
        if (b == (w % WIN)) begin step(pol, !pol); pol = !pol; end
        else step(0, 0);
      end
    for (int b = 0; b < WIN; b++) step(0, 0);
    chk(lost == 1, "R8 empty window keeps loss", lost, 1);
    for (int w = 0; w < CLRW; w++)
      for (int b = 0; b < WIN; b++) begin
        if (b == WIN - 1 - (w % 3)) begin step(pol, !pol); pol = !pol; end
        else step(0, 0);
        if (w == CLRW - 1 && b == WIN - 2)
          chk(lost == 1, "R8 before last bit", lost, 1);
      end
    chk(lost == 0, "R8 released on 24th window", lost, 0);

    // sweep: pseudo-random bipolar line
    lf = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      case (lf[2:0])
        3'd4: step(1, 0);
        3'd5: step(0, 1);
        3'd6: begin step(pol, !pol); pol = !pol; end
        3'd7: step(1, 1);
        default: step(0, 0);
      endcase
      if (i % 1000 == 500) for (int z = 0; z < 200; z++) step(0, 0);
    end
    // sweep: tied rails (NRZ input)
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      step(lf[0], lf[0]);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule